// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the per-vector state of a local interrupt controller. It holds three bit vectors, one entry per interrupt vector (256 by default): requests waiting for service, vectors now in service, and the trigger kind of each vector. A request port sets a vector's request bit and records whether that vector is level or edge triggered. Vectors are grouped into priority classes of sixteen, and the class is the upper nibble of the vector number.

The processor priority merges a stored task priority value with the class of the highest vector in service. A pending vector is offered to the processor only if it belongs to a class strictly above that priority. When the processor acknowledges, the block answers with the winning vector and moves it from the request set to the in-service set. If nothing may be offered, it answers with a spurious vector and changes no state. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level triggered, a one-cycle broadcast pulse carrying the vector is sent so that the interrupt source can re-arm.

Top module: `vprio_core`

## Requirements
- R1: During and after reset the request, in-service and trigger sets are empty and the task priority is 0, so `irq_o`, `ack_valid_o` and `eoi_bcast_o` are low and `ppr_o` is 0.
- R2: A cycle with `set_i` high sets the request bit of `set_vec_i` and writes that vector's trigger bit from `set_level_i` (1 = level, 0 = edge). A later request for the same vector overwrites the trigger bit.
- R3: The highest pending vector is the highest-numbered set bit over the whole request set, so the vector number decides priority across all 32-bit words and within each word.
- R4: A cycle with `tpr_we_i` high loads the task priority from `tpr_wdata_i` at the next edge. `ppr_o` equals the task priority when its bits 7:4 are at least the class (bits 7:4) of the highest in-service vector, and otherwise equals that class followed by four zero bits. An empty in-service set counts as class 0.
- R5: `irq_o` is high exactly when `sw_enable_i` is high, a request is pending, and either `ppr_o` is 0 or the class of the highest pending vector is strictly greater than bits 7:4 of `ppr_o`. It reflects stored state from the cycle after any change.
- R6: A one-cycle `ack_i` while `irq_o` is high raises `ack_valid_o` for one cycle after the edge, with `ack_vector_o` set to the highest pending vector. That vector's request bit is cleared and its in-service bit is set.
- R7: An `ack_i` while `irq_o` is low, whether the request is blocked, the set is empty or the block is disabled, returns `spurious_vec_i` on `ack_vector_o` and leaves the request and in-service sets unchanged.
- R8: A one-cycle `eoi_i` clears only the highest set in-service bit, and has no effect when the in-service set is empty.
- R9: If the vector retired by `eoi_i` has its trigger bit set and `directed_eoi_i` is low, `eoi_bcast_o` pulses for one cycle after the edge with `eoi_bcast_vec_o` equal to that vector. Otherwise no pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 1 | Request strobe |
| set_vec_i | input | 8 | Vector being requested |
| set_level_i | input | 1 | Trigger kind of the request, 1 = level |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 8 | New task priority |
| sw_enable_i | input | 1 | Software enable; while low nothing is offered |
| spurious_vec_i | input | 8 | Vector returned when an acknowledge cannot be granted |
| directed_eoi_i | input | 1 | Suppresses the end-of-interrupt broadcast |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| ack_valid_o | output | 1 | Acknowledge response valid, one cycle |
| ack_vector_o | output | 8 | Granted or spurious vector |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_bcast_o | output | 1 | Level-triggered end-of-interrupt broadcast pulse |
| eoi_bcast_vec_o | output | 8 | Vector carried by the broadcast |
| irq_o | output | 1 | A presentable vector exists |
| ppr_o | output | 8 | Current processor priority |

## Verification
The bench targets the class boundary. A task priority in the same class as the pending vector must block it, and a priority of exactly zero must let class-0 vectors through. A design that compared full bytes or used greater-or-equal would offer the vector or withhold it wrongly, and this shows up on `irq_o` and in the acknowledge answer. Blocked and disabled acknowledges are followed by a grant that must still find the same vector pending, so a design that dropped the bit on a spurious answer would lose an interrupt. Vectors spread over every word, including 0, 31, 32 and 255, are drained one by one against a behavioural search, which exposes word or bit ordering faults in the two-level search. A vector re-requested as edge after a level request must produce no broadcast, and neither may a level vector retired while directed EOI is set.

// File: rtl/vprio_pkg.sv
package vprio_pkg;
   localparam int unsigned VPRIO_NUM_VEC_DEF = 256;
   localparam int unsigned VPRIO_WORD_W_DEF  = 32;
   localparam int unsigned VPRIO_CLASS_LSB   = 4;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;
endpackage

// File: rtl/vprio_fls.sv
module vprio_fls #(
   parameter int unsigned WORDS     = 8,
   parameter int unsigned WORD_W    = 32,
   parameter bit          TWO_LEVEL = 1'b1,
   localparam int unsigned NUM    = WORDS * WORD_W,
   localparam int unsigned IDX_W  = $clog2(NUM),
   localparam int unsigned WSEL_W = $clog2(WORDS),
   localparam int unsigned BSEL_W = $clog2(WORD_W)
) (
   input  logic [NUM-1:0]   vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   if (WORDS < 2 || WORD_W < 2) begin : g_bad_shape
      $error("vprio_fls: WORDS and WORD_W must both be at least 2");
   end

   if (TWO_LEVEL) begin : g_two_level
      logic [WORDS-1:0]  word_any;
      logic [WSEL_W-1:0] wsel;
      logic [BSEL_W-1:0] bsel;
      logic [WORD_W-1:0] sel_word;

      for (genvar w = 0; w < WORDS; w++) begin : g_word
         assign word_any[w] = |vec_i[w*WORD_W +: WORD_W];
      end

      always_comb begin
         wsel = '0;
         for (int w = 0; w < WORDS; w++) begin
            if (word_any[w]) wsel = WSEL_W'(w);
         end
      end

      assign sel_word = vec_i[wsel*WORD_W +: WORD_W];

      always_comb begin
         bsel = '0;
         for (int b = 0; b < WORD_W; b++) begin
            if (sel_word[b]) bsel = BSEL_W'(b);
         end
      end

      assign any_o = |word_any;
      assign idx_o = {wsel, bsel};
   end else begin : g_flat
      always_comb begin
         idx_o = '0;
         for (int b = 0; b < NUM; b++) begin
            if (vec_i[b]) idx_o = IDX_W'(b);
         end
      end
      assign any_o = |vec_i;
   end
endmodule

// File: rtl/vprio_ppr.sv
module vprio_ppr #(
   parameter int unsigned VEC_W     = 8,
   parameter int unsigned CLASS_LSB = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [VEC_W-1:0] tpr_i,
   input  logic             isr_any_i,
   input  logic [VEC_W-1:0] isr_idx_i,
   input  logic             irr_any_i,
   input  logic [VEC_W-1:0] irr_idx_i,
   input  logic             enable_i,
   output logic [VEC_W-1:0] ppr_o,
   output logic             present_o
);
   localparam int unsigned CLS_W = VEC_W - CLASS_LSB;

   logic [CLS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

   assign tpr_cls = tpr_i[VEC_W-1:CLASS_LSB];
   assign isr_cls = isr_any_i ? isr_idx_i[VEC_W-1:CLASS_LSB] : '0;
   assign irr_cls = irr_idx_i[VEC_W-1:CLASS_LSB];

   assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {CLASS_LSB{1'b0}}};
   assign ppr_cls = ppr_o[VEC_W-1:CLASS_LSB];

   assign present_o = enable_i && irr_any_i &&
                      ((ppr_o == '0) || (irr_cls > ppr_cls));

   // R4
   ppr_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ppr_o >= tpr_i);

   // R5
   present_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      present_o |-> (enable_i && irr_any_i));
endmodule

// File: rtl/vprio_core.sv
module vprio_core #(
   parameter int unsigned NUM_VEC   = vprio_pkg::VPRIO_NUM_VEC_DEF,
   parameter int unsigned WORD_W    = vprio_pkg::VPRIO_WORD_W_DEF,
   parameter int unsigned CLASS_LSB = vprio_pkg::VPRIO_CLASS_LSB,
   parameter bit          TWO_LEVEL = 1'b1,
   localparam int unsigned VEC_W    = $clog2(NUM_VEC),
   localparam int unsigned WORDS    = NUM_VEC / WORD_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             set_i,
   input  logic [VEC_W-1:0] set_vec_i,
   input  logic             set_level_i,
   input  logic             tpr_we_i,
   input  logic [VEC_W-1:0] tpr_wdata_i,
   input  logic             sw_enable_i,
   input  logic [VEC_W-1:0] spurious_vec_i,
   input  logic             directed_eoi_i,
   input  logic             ack_i,
   output logic             ack_valid_o,
   output logic [VEC_W-1:0] ack_vector_o,
   input  logic             eoi_i,
   output logic             eoi_bcast_o,
   output logic [VEC_W-1:0] eoi_bcast_vec_o,
   output logic             irq_o,
   output logic [VEC_W-1:0] ppr_o
);
   import vprio_pkg::*;

   if ((1 << VEC_W) != NUM_VEC) begin : g_bad_num
      $error("vprio_core: NUM_VEC must be a power of two");
   end
   if (NUM_VEC % WORD_W != 0) begin : g_bad_word
      $error("vprio_core: NUM_VEC must be a multiple of WORD_W");
   end
   if (VEC_W <= CLASS_LSB) begin : g_bad_class
      $error("vprio_core: class field leaves no priority bits");
   end

   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
   logic [VEC_W-1:0]   tpr_q;
   logic               irr_any, isr_any, present;
   logic [VEC_W-1:0]   irr_idx, isr_idx;
   logic               eoi_hit;

   vprio_fls #(.WORDS(WORDS), .WORD_W(WORD_W), .TWO_LEVEL(TWO_LEVEL)) irr_fls_i (
      .vec_i (irr_q),
      .any_o (irr_any),
      .idx_o (irr_idx)
   );

   vprio_fls #(.WORDS(WORDS), .WORD_W(WORD_W), .TWO_LEVEL(TWO_LEVEL)) isr_fls_i (
      .vec_i (isr_q),
      .any_o (isr_any),
      .idx_o (isr_idx)
   );

   vprio_ppr #(.VEC_W(VEC_W), .CLASS_LSB(CLASS_LSB)) ppr_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tpr_i     (tpr_q),
      .isr_any_i (isr_any),
      .isr_idx_i (isr_idx),
      .irr_any_i (irr_any),
      .irr_idx_i (irr_idx),
      .enable_i  (sw_enable_i),
      .ppr_o     (ppr_o),
      .present_o (present)
   );

   assign eoi_hit = eoi_i && isr_any;

   // retire first, then grant, then new request: later steps win on the same bit
   always_comb begin
      irr_d = irr_q;
      isr_d = isr_q;
      tmr_d = tmr_q;
      if (eoi_hit) isr_d[isr_idx] = 1'b0;
      if (ack_i && present) begin
         irr_d[irr_idx] = 1'b0;
         isr_d[irr_idx] = 1'b1;
      end
      if (set_i) begin
         irr_d[set_vec_i] = 1'b1;
         tmr_d[set_vec_i] = set_level_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irr_q           <= '0;
         isr_q           <= '0;
         tmr_q           <= '0;
         tpr_q           <= '0;
         ack_valid_o     <= 1'b0;
         ack_vector_o    <= '0;
         eoi_bcast_o     <= 1'b0;
         eoi_bcast_vec_o <= '0;
      end else begin
         irr_q       <= irr_d;
         isr_q       <= isr_d;
         tmr_q       <= tmr_d;
         ack_valid_o <= ack_i;
         eoi_bcast_o <= eoi_hit && (tmr_q[isr_idx] == TRIG_LEVEL) && !directed_eoi_i;
         if (tpr_we_i) tpr_q <= tpr_wdata_i;
         if (ack_i)    ack_vector_o <= present ? irr_idx : spurious_vec_i;
         if (eoi_hit)  eoi_bcast_vec_o <= isr_idx;
      end
   end

   assign irq_o = present;

   // R6
   ack_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && irq_o && !set_i) |=>
         (isr_q[$past(irr_idx)] && !irr_q[$past(irr_idx)] &&
          ack_valid_o && (ack_vector_o == $past(irr_idx))));

   // R6
   ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_valid_o |-> $past(ack_i));

   // R7
   ack_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !irq_o && !set_i && !eoi_i) |=>
         ($stable(irr_q) && $stable(isr_q) && (ack_vector_o == $past(spurious_vec_i))));

   // R8
   eoi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i && isr_any && !ack_i) |=>
         ($countones(isr_q) == $past($countones(isr_q)) - 1));

   // R9
   bcast_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eoi_bcast_o |-> $past(eoi_i && !directed_eoi_i));
endmodule

// File: tb/vprio_core_tb.sv
module vprio_core_tb_top;
   localparam int CLK_PERIOD = 10;

   localparam logic [1:0] OP_SET = 2'd0;
   localparam logic [1:0] OP_TPR = 2'd1;
   localparam logic [1:0] OP_ACK = 2'd2;
   localparam logic [1:0] OP_EOI = 2'd3;
   localparam logic [7:0] SPUR   = 8'hA7;

   // {op, data, level, exp_irq, exp_ppr, exp_vec, exp_bcast}
   localparam int NSTEP = 19;
   localparam logic [28:0] TBL [NSTEP] = '{
      {OP_SET, 8'h45, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},
      {OP_SET, 8'h93, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0},
      {OP_TPR, 8'h80, 1'b0, 1'b1, 8'h80, 8'h00, 1'b0},
      {OP_TPR, 8'h95, 1'b0, 1'b0, 8'h95, 8'h00, 1'b0},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h95, SPUR,  1'b0},
      {OP_TPR, 8'h10, 1'b0, 1'b1, 8'h10, 8'h00, 1'b0},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h90, 8'h93, 1'b0},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h90, SPUR,  1'b0},
      {OP_SET, 8'hA1, 1'b0, 1'b1, 8'h90, 8'h00, 1'b0},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'hA0, 8'hA1, 1'b0},
      {OP_EOI, 8'h00, 1'b0, 1'b0, 8'h90, 8'h00, 1'b0},
      {OP_EOI, 8'h00, 1'b0, 1'b1, 8'h10, 8'h93, 1'b1},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h40, 8'h45, 1'b0},
      {OP_EOI, 8'h00, 1'b0, 1'b0, 8'h10, 8'h00, 1'b0},
      {OP_SET, 8'h0F, 1'b1, 1'b0, 8'h10, 8'h00, 1'b0},
      {OP_TPR, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},
      {OP_SET, 8'h0F, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},
      {OP_ACK, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0F, 1'b0},
      {OP_EOI, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic       set_s, set_lvl, tpr_we, sw_en, dir_eoi, ack, eoi;
   logic [7:0] set_vec, tpr_wd, spur;
   logic       ack_valid, bcast, irq;
   logic [7:0] ack_vec, bcast_vec, ppr;

   int checks = 0;
   int errors = 0;
   logic [255:0] model;

   always #(CLK_PERIOD/2) clk = ~clk;

   vprio_core dut_i (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .set_i           (set_s),
      .set_vec_i       (set_vec),
      .set_level_i     (set_lvl),
      .tpr_we_i        (tpr_we),
      .tpr_wdata_i     (tpr_wd),
      .sw_enable_i     (sw_en),
      .spurious_vec_i  (spur),
      .directed_eoi_i  (dir_eoi),
      .ack_i           (ack),
      .ack_valid_o     (ack_valid),
      .ack_vector_o    (ack_vec),
      .eoi_i           (eoi),
      .eoi_bcast_o     (bcast),
      .eoi_bcast_vec_o (bcast_vec),
      .irq_o           (irq),
      .ppr_o           (ppr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] op, input logic [7:0] data, input logic lvl);
      @(negedge clk);
      case (op)
         OP_SET: begin set_s = 1'b1; set_vec = data; set_lvl = lvl; end
         OP_TPR: begin tpr_we = 1'b1; tpr_wd = data; end
         OP_ACK: ack = 1'b1;
         default: eoi = 1'b1;
      endcase
      @(posedge clk);
      #1;
      set_s = 1'b0; tpr_we = 1'b0; ack = 1'b0; eoi = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; set_s = 1'b0; set_lvl = 1'b0; tpr_we = 1'b0; sw_en = 1'b1;
      dir_eoi = 1'b0; ack = 1'b0; eoi = 1'b0; set_vec = '0; tpr_wd = '0; spur = SPUR;
      repeat (3) @(posedge clk);
      #1;
      check("R1 irq in reset", irq, 0);
      check("R1 ppr in reset", ppr, 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 ack_valid after reset", ack_valid, 0);
      check("R1 bcast after reset", bcast, 0);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NSTEP; i++) begin
         logic [28:0] e;
         e = TBL[i];
         do_op(e[28:27], e[26:19], e[18]);
         check($sformatf("R5 irq step %0d", i), irq, e[17]);
         check($sformatf("R4 ppr step %0d", i), ppr, e[16:9]);
         if (e[28:27] == OP_ACK) begin
            check($sformatf("R6/R7 ack_valid step %0d", i), ack_valid, 1);
            check($sformatf("R6/R7 ack vector step %0d", i), ack_vec, e[8:1]);
         end
         if (e[28:27] == OP_EOI) begin
            check($sformatf("R9 bcast step %0d", i), bcast, e[0]);
            if (e[0]) check($sformatf("R9 bcast vector step %0d", i), bcast_vec, e[8:1]);
         end
      end

      // reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      do_op(OP_SET, 8'h77, 1'b1);
      #1;
      check("R1 set ignored in reset", irq, 0);
      @(negedge clk);
      rst_n = 1'b1;
      do_op(OP_ACK, 8'h00, 1'b0);
      check("R7 ack on empty set returns spurious", ack_vec, SPUR);
      check("R1 no request after reset", irq, 0);

      // disabled block offers nothing and keeps state
      do_op(OP_SET, 8'h60, 1'b1);
      sw_en = 1'b0;
      #1;
      check("R5 irq low while disabled", irq, 0);
      do_op(OP_ACK, 8'h00, 1'b0);
      check("R7 disabled ack returns spurious", ack_vec, SPUR);
      sw_en = 1'b1;
      #1;
      check("R5 irq back after enable", irq, 1);
      do_op(OP_ACK, 8'h00, 1'b0);
      check("R6 request kept across disabled ack", ack_vec, 8'h60);
      check("R4 ppr follows in-service class", ppr, 8'h60);
      dir_eoi = 1'b1;
      do_op(OP_EOI, 8'h00, 1'b0);
      check("R9 directed eoi suppresses broadcast", bcast, 0);
      check("R8 in-service retired", ppr, 8'h00);
      dir_eoi = 1'b0;
      do_op(OP_EOI, 8'h00, 1'b0);
      check("R8 eoi on empty set no broadcast", bcast, 0);
      check("R8 eoi on empty set keeps ppr", ppr, 8'h00);

      // R3: drain a spread of vectors against a behavioural search
      model = '0;
      for (int k = 0; k < 24; k++) begin
         logic [7:0] v;
         v = 8'((k * 37) % 256);
         model[v] = 1'b1;
         do_op(OP_SET, v, 1'b0);
      end
      foreach (model[k]) if (k == 0 || k == 31 || k == 32 || k == 255) begin
         model[k] = 1'b1;
         do_op(OP_SET, 8'(k), 1'b0);
      end
      while (model != '0) begin
         int exp_v;
         exp_v = 0;
         for (int k = 0; k < 256; k++) if (model[k]) exp_v = k;
         check("R5 irq with pending vector", irq, 1);
         do_op(OP_ACK, 8'h00, 1'b0);
         check("R3 highest vector granted", ack_vec, exp_v);
         model[exp_v] = 1'b0;
         do_op(OP_EOI, 8'h00, 1'b0);
         check("R9 edge vector no broadcast", bcast, 0);
      end
      check("R5 irq low when drained", irq, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule